// File: doc/BRIEF.md
# Program Counter Sequencer with One Delay Slot

This block produces the fetch address for a stream of 32-bit instructions that sit on four-byte boundaries. Each cycle in which fetch advances, it looks at the instruction word fetched at the current address. The address normally moves on by four. Two kinds of instruction transfer control:

- **Direct jump:** carries a 26-bit word index.
- **Register jump:** takes its destination from a register operand supplied by the surrounding pipeline.

Neither transfer takes effect at once. The word stored right after the jump is always fetched next and is marked as the delay-slot instruction. Only the advance after that loads the destination.

A direct jump keeps the upper four address bits of the delay-slot instruction, so it reaches only the 256 MB region that contains that slot. A register jump can reach any word address.

A jump placed in a delay slot is not given a meaning. The block ignores the second jump and raises a one-cycle error pulse, so that the sequence stays deterministic. Conditional branches, the register file, instruction memory and the execution of all other instructions belong to other blocks.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the address to BOOT_ADDR (default 0x00400000) and clears the delay-slot flag and the error flag.
- R2: On an advance with no pending slot and no jump fetched, the address becomes address+4, the slot flag stays 0 and the error flag stays 0.
- R3: A word whose bits 31:26 equal 000010 is a direct jump. The next advance steps to address+4 with the slot flag high. The advance after that loads {slot address[31:28], word[25:0], 2'b00}.
- R4: A direct jump stays inside the region of the slot address. Index 0 gives region base + 0. Index 0x3FFFFFF gives region base + 0x0FFFFFFC.
- R5: After any jump, the very next fetched address is the jump address + 4, and the slot flag is high for exactly that one fetch.
- R6: A word with bits 31:26 = 000000 and bits 5:0 = 001000 is a register jump. The operand sampled on the advance that leaves the jump becomes the destination, with bits 1:0 forced to 0. The address therefore stays word aligned.
- R7: While the advance enable is low, the address, the slot flag and the pending destination hold their values.
- R8: The upper four bits of a direct-jump destination come from the slot address (jump address + 4), not from the jump address. A jump in the last word of a region therefore lands in the following region.
- R9: A jump of either kind fetched in a delay slot is ignored. The slot advance still loads the first destination with the slot flag low, and the error flag is high for the one cycle after that advance and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Fetch advance enable; the state moves only when high |
| instr | input | 32 | Instruction word fetched at pc_out |
| reg_val | input | 32 | Register operand used by a register jump |
| pc_out | output | 32 | Current fetch address (registered) |
| in_slot | output | 1 | High while pc_out addresses a delay-slot instruction |
| nested_err | output | 1 | One-cycle pulse after a jump was found in a delay slot |

## Verification
Two functions can fall in the same cycle: loading the pending destination at the end of a delay slot, and decoding a fresh jump in the word that occupies that slot. The bench provokes this by placing a direct jump in the slot of another direct jump. It judges the result by requiring that the address moves to the first destination, the slot flag drops, and the error pulse appears for one cycle only. The stalled-advance case is also tested while a destination is pending, including a stall that falls in the middle of a slot.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_JDIR    = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
  localparam logic [OPC_W-1:0] FN_JREG     = 6'b001000;

  typedef enum logic [1:0] {
    FLOW_SEQ  = 2'd0,
    FLOW_JDIR = 2'd1,
    FLOW_JREG = 2'd2
  } flow_e;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]      instr,
  output flow_e                kind,
  output logic [XLEN-OPC_W-1:0] jidx
);
  logic [OPC_W-1:0] opc;
  logic [OPC_W-1:0] fn;

  assign opc  = instr[XLEN-1 -: OPC_W];
  assign fn   = instr[OPC_W-1:0];
  assign jidx = instr[XLEN-OPC_W-1:0];

  always_comb begin
    kind = FLOW_SEQ;
    if (opc == OPC_JDIR) begin
      kind = FLOW_JDIR;
    end else if (opc == OPC_SPECIAL && fn == FN_JREG) begin
      kind = FLOW_JREG;
    end
  end
endmodule

// File: rtl/pcs_target.sv
module pcs_target
  import pcs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e                      kind,
  input  logic [OPC_W-3:0]           region,
  input  logic [XLEN-OPC_W-1:0]      jidx,
  input  logic [XLEN-1:0]            reg_val,
  output logic [XLEN-1:0]            tgt
);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  always_comb begin
    case (kind)
      FLOW_JDIR: tgt = {region, jidx, 2'b00};
      FLOW_JREG: tgt = reg_val & ALIGN_MASK;
      default:   tgt = '0;
    endcase
  end
endmodule

// File: rtl/pcs_state.sv
module pcs_state
  import pcs_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_en,
  input  flow_e           kind,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] new_tgt,
  output logic [XLEN-1:0] pc_q,
  output logic            slot_q,
  output logic            err_q
);
  logic [XLEN-1:0] tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= BOOT_ADDR;
      slot_q <= 1'b0;
      tgt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (adv_en) begin
        if (slot_q) begin
          pc_q   <= tgt_q;
          slot_q <= 1'b0;
          err_q  <= (kind != FLOW_SEQ);
        end else begin
          pc_q <= seq_pc;
          if (kind != FLOW_SEQ) begin
            slot_q <= 1'b1;
            tgt_q  <= new_tgt;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcs_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_en,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] reg_val,
  output logic [XLEN-1:0] pc_out,
  output logic            in_slot,
  output logic            nested_err
);
  localparam int IDX_W    = XLEN - OPC_W;
  localparam int REGION_W = XLEN - IDX_W - 2;

  flow_e               kind;
  logic [IDX_W-1:0]    jidx;
  logic [XLEN-1:0]     pc_q;
  logic [XLEN-1:0]     seq_pc;
  logic [XLEN-1:0]     new_tgt;
  logic                slot_q;
  logic                err_q;

  assign seq_pc = pc_q + XLEN'(4);

  pcs_decode #(.XLEN(XLEN)) u_dec (
    .instr (instr),
    .kind  (kind),
    .jidx  (jidx)
  );

  pcs_target #(.XLEN(XLEN)) u_tgt (
    .kind    (kind),
    .region  (seq_pc[XLEN-1 -: REGION_W]),
    .jidx    (jidx),
    .reg_val (reg_val),
    .tgt     (new_tgt)
  );

  pcs_state #(.XLEN(XLEN), .BOOT_ADDR(BOOT_ADDR)) u_st (
    .clk     (clk),
    .rst     (rst),
    .adv_en  (adv_en),
    .kind    (kind),
    .seq_pc  (seq_pc),
    .new_tgt (new_tgt),
    .pc_q    (pc_q),
    .slot_q  (slot_q),
    .err_q   (err_q)
  );

  assign pc_out     = pc_q;
  assign in_slot    = slot_q;
  assign nested_err = err_q;
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            adv_en,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] reg_val,
  input logic [XLEN-1:0] pc_out,
  input logic            in_slot,
  input logic            nested_err
);
  logic            is_d;
  logic            is_r;
  logic            is_j;
  logic [XLEN-1:0] pc4;
  logic [XLEN-1:0] shadow;

  assign is_d = (instr[XLEN-1 -: 6] == 6'b000010);
  assign is_r = (instr[XLEN-1 -: 6] == 6'b000000) && (instr[5:0] == 6'b001000);
  assign is_j = is_d || is_r;
  assign pc4  = pc_out + XLEN'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (adv_en && !in_slot && is_j) begin
      shadow <= is_d ? {pc4[XLEN-1 -: 4], instr[XLEN-7:0], 2'b00}
                     : (reg_val & ~XLEN'(3));
    end
  end

  assert_pc_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    pc_out[1:0] == 2'b00);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> ($stable(pc_out) && $stable(in_slot)));

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !in_slot && !is_j) |=> (pc_out == $past(pc_out) + XLEN'(4)) && !in_slot);

  assert_slot_enter_R5: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !in_slot && is_j) |=> in_slot && (pc_out == $past(pc_out) + XLEN'(4)));

  assert_slot_once_R5: assert property (@(posedge clk) disable iff (rst)
    (adv_en && in_slot) |=> !in_slot);

  assert_redirect_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_en && in_slot) |=> (pc_out == $past(shadow)));

  assert_nested_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (adv_en && in_slot && is_j) |=> nested_err);

  assert_nested_cause_R9: assert property (@(posedge clk) disable iff (rst)
    nested_err |-> ($past(in_slot) && $past(adv_en)));
endmodule

bind pc_sequencer pcs_checker #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .adv_en     (adv_en),
  .instr      (instr),
  .reg_val    (reg_val),
  .pc_out     (pc_out),
  .in_slot    (in_slot),
  .nested_err (nested_err)
);

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/1ps
module sim_pc_sequencer;
  localparam logic [31:0] BOOT = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic [31:0] reg_val = '0;
  logic [31:0] instr;
  logic [31:0] pc_out;
  logic        in_slot;
  logic        nested_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pc_sequencer u0 (
    .clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr), .reg_val(reg_val),
    .pc_out(pc_out), .in_slot(in_slot), .nested_err(nested_err)
  );

  logic [31:0] imem [logic [31:0]];

  function automatic logic [31:0] fetch(input logic [31:0] a);
    if (imem.exists(a)) return imem[a];
    return 32'h0;
  endfunction

  always @* instr = fetch(pc_out);

  function automatic logic [31:0] j_op(input logic [25:0] idx);
    return {6'b000010, idx};
  endfunction
  localparam logic [31:0] JR_OP = {6'b000000, 5'd5, 15'd0, 6'b001000};

  typedef struct {
    logic [31:0] pc;
    logic        slot;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  // behavioural model built from the requirements
  logic [31:0] m_pc, m_tgt;
  logic        m_slot, m_err;
  string       m_tag;

  task automatic step(input logic adv, input logic [31:0] rv, input logic r);
    exp_t e;
    logic [31:0] w, p4;
    logic d, j, n_err;
    @(negedge clk);
    e.pc = m_pc; e.slot = m_slot; e.err = m_err; e.tag = m_tag;
    sbq.push_back(e);
    adv_en  = adv;
    reg_val = rv;
    rst     = r;
    if (r) begin
      m_pc = BOOT; m_slot = 0; m_err = 0; m_tgt = '0; m_tag = "R1 reset";
    end else begin
      w = fetch(m_pc);
      d = (w[31:26] == 6'b000010);
      j = d || (w[31:26] == 6'b000000 && w[5:0] == 6'b001000);
      n_err = adv && m_slot && j;
      if (!adv) begin
        m_tag = "R7 hold";
      end else if (m_slot) begin
        m_pc = m_tgt; m_slot = 0;
        m_tag = n_err ? "R9 nested jump" : "R3 R4 R6 R8 redirect";
      end else begin
        p4 = m_pc + 32'd4;
        if (d) begin
          m_tgt = {p4[31:28], w[25:0], 2'b00}; m_slot = 1; m_tag = "R5 slot after direct";
        end else if (j) begin
          m_tgt = rv & ~32'h3; m_slot = 1; m_tag = "R5 R6 slot after register";
        end else begin
          m_tag = "R2 sequential";
        end
        m_pc = p4;
      end
      m_err = n_err;
    end
  endtask

  // monitor: compares the state visible before the next rising edge
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (sbq.size() > 0) begin
      e = sbq.pop_front();
      checks++;
      if (pc_out !== e.pc || in_slot !== e.slot || nested_err !== e.err) begin
        errors++;
        $display("FAIL %s: pc=%h slot=%b err=%b expected pc=%h slot=%b err=%b",
                 e.tag, pc_out, in_slot, nested_err, e.pc, e.slot, e.err);
      end
    end
  end

  initial begin
    // program: boot loop and region crossings
    imem[32'h0040_0010] = j_op(26'h010_0008);   // -> 0x00400020
    imem[32'h0040_0020] = JR_OP;                 // -> 0x0FFFFFF4 (operand 0x0FFFFFF7)
    imem[32'h0FFF_FFFC] = j_op(26'h000_0010);   // slot 0x10000000 -> 0x10000040
    imem[32'h1000_0040] = j_op(26'h3FF_FFFF);   // -> 0x1FFFFFFC
    imem[32'h1000_0044] = j_op(26'h000_0000);   // jump in slot: ignored
    imem[32'h1FFF_FFFC] = j_op(26'h000_0000);   // slot 0x20000000 -> 0x20000000
    imem[32'h2000_0010] = JR_OP;                 // -> 0x00400000 (operand 0x00400003)
    imem[32'h2000_0014] = JR_OP;                 // register jump in slot: ignored

    m_pc = BOOT; m_slot = 0; m_err = 0; m_tgt = '0; m_tag = "R1 reset";
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    step(1'b0, 32'h0, 1'b0);                     // R1 reset state observed
    for (int i = 0; i < 70; i++) begin
      logic [31:0] rv;
      rv = (m_pc == 32'h2000_0010) ? 32'h0040_0003 : 32'h0FFF_FFF7;
      step((i % 7) != 4, rv, 1'b0);
    end
    step(1'b1, 32'h0, 1'b1);                     // R1 mid-run reset
    step(1'b1, 32'h0, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b1, 32'h0FFF_FFF7, 1'b0);
    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule